// File: doc/BRIEF.md
# Pipelined AHB-Lite Register Memory Slave

This block is a single-master AHB-Lite slave that sits in front of a small word-organised register memory. Bus transfers are pipelined: a transfer's address and control are presented for one cycle, and the block answers in the data phase that follows. The next transfer's address phase overlaps that data phase. The block keeps a registered copy of the accepted control and uses that copy to finish the access, because by then the bus lines already carry the next request.

Only non-sequential and sequential transfer requests start an access. Idle and busy requests, and requests that arrive while the slave is not selected, get a zero-wait, no-effect reply. A build-time wait count stretches every real data phase by holding the ready output low for that many cycles. Sub-word writes touch only the byte lanes that the transfer size and the low address bits select. The response is always OKAY.

Top module: `ahbl_mem_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_ready_out` is 1, `bus_resp` is 0 and `bus_rdata` is 0. Memory words read as 0 until they are written.
- R2: An access starts only when `bus_sel` is 1, `bus_ready` is 1 and `bus_trans` is 2'b10 (single or first beat) or 2'b11 (following beat). A request with `bus_trans` 2'b00 (idle) or 2'b01 (busy), or with `bus_sel` 0, leaves memory unchanged and keeps `bus_ready_out` at 1 in the following cycle.
- R3: After each accepted request, `bus_ready_out` is 0 for exactly WAIT_STATES cycles and is then 1 for the final cycle of that data phase.
- R4: A write with `bus_size` 3'b010 (word) stores the `bus_wdata` value present in the final data-phase cycle.
- R5: In the final cycle of a read data phase, `bus_rdata` equals the memory word at the registered address. Outside read data phases `bus_rdata` is 0.
- R6: A write with `bus_size` 3'b000 (byte) updates only bits 8k+7:8k, where k is the value of address bits 1:0, and takes the byte from those same bits of `bus_wdata`.
- R7: A write with `bus_size` 3'b001 (halfword) updates only the 16-bit half that address bit 1 selects: 0 selects bits 15:0 and 1 selects bits 31:16.
- R8: The data phase uses the address, direction and size captured in the address phase, whatever the bus carries during it. When a write is followed at once by a read of the same word, the read returns the newly written data.
- R9: `bus_resp` is 0 (OKAY) in every cycle.
- R10: The word index is taken from address bits log2(DEPTH)+1:2. Higher address bits are ignored, so addresses DEPTH*4 bytes apart reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Slave select from the address decoder |
| bus_addr | input | ADDR_W | Byte address of the current address phase |
| bus_trans | input | 2 | Transfer kind: 00 idle, 01 busy, 10 first/single, 11 following |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 3 | log2 of the number of bytes moved |
| bus_wdata | input | DATA_W | Write data, valid during the data phase |
| bus_ready | input | 1 | Bus-wide ready; when 1, the current address phase is accepted |
| bus_rdata | output | DATA_W | Read data, valid in the final read data-phase cycle |
| bus_ready_out | output | 1 | 0 to stretch this slave's data phase |
| bus_resp | output | 1 | Transfer response, always OKAY (0) |

## Verification
If the captured control is wrong, the fault appears one data phase late. A stale address or direction shows up as the wrong word or the wrong lanes on a later readback, or as a read that returns nonzero data in a write phase. If the wait counter is wrong, the ready output stays low for a different number of cycles, and that count is visible in the very first data phase after the fault. If an idle or busy request is taken as an access, ready drops in the next cycle and the memory word is corrupted, which the next readback of that word reveals.

// File: rtl/ahbl_mem_pkg.sv
package ahbl_mem_pkg;

   // transfer kind carried on the two-bit request field
   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_kind_e;

   // encoded transfer size (log2 of bytes)
   typedef enum logic [2:0] {
      SZ_BYTE = 3'b000,
      SZ_HALF = 3'b001,
      SZ_WORD = 3'b010
   } xfer_size_e;

   localparam logic RESP_OKAY = 1'b0;

   // a request opens a data phase only for the two "real" kinds
   function automatic logic is_real_request(input logic [1:0] kind);
      return (kind == TR_NONSEQ) || (kind == TR_SEQ);
   endfunction

endpackage

// File: rtl/ahbl_mem_capture.sv
module ahbl_mem_capture
   import ahbl_mem_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int KEEP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [1:0]        kind,
   input  logic              ready_in,
   input  logic              write_in,
   input  logic [2:0]        size_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              accept,
   output logic              dp_active,
   output logic              dp_write,
   output logic [2:0]        dp_size,
   output logic [KEEP_W-1:0] dp_addr
);

   if (KEEP_W < 1 || KEEP_W >= ADDR_W) begin : g_bad_keep
      $error("capture: KEEP_W must lie in 1..ADDR_W-1");
   end

   // upper address bits alias onto the same words
   logic unused_addr_hi;
   assign unused_addr_hi = ^addr_in[ADDR_W-1:KEEP_W];

   assign accept = sel && ready_in && is_real_request(kind);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_active <= 1'b0;
         dp_write  <= 1'b0;
         dp_size   <= SZ_WORD;
         dp_addr   <= '0;
      end else if (ready_in) begin
         dp_active <= accept;
         if (accept) begin
            dp_write <= write_in;
            dp_size  <= size_in;
            dp_addr  <= addr_in[KEEP_W-1:0];
         end
      end
   end

   // R8
   dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_active && !ready_in) |=>
         (dp_active && $stable(dp_addr) && $stable(dp_write) && $stable(dp_size)));

endmodule

// File: rtl/ahbl_mem_waitgen.sv
module ahbl_mem_waitgen #(
   parameter int WAIT_STATES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   output logic ready_o
);

   if (WAIT_STATES < 0 || WAIT_STATES > 255) begin : g_bad_wait
      $error("waitgen: WAIT_STATES must lie in 0..255");
   end

   if (WAIT_STATES == 0) begin : g_nowait
      logic unused_wait0;
      assign unused_wait0 = clk ^ rst_n ^ accept;
      assign ready_o = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(WAIT_STATES + 1);
      localparam logic [CW-1:0] LOAD = CW'(WAIT_STATES);
      logic [CW-1:0] remain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               remain <= '0;
         else if (accept)          remain <= LOAD;
         else if (remain != '0)    remain <= remain - 1'b1;
      end

      assign ready_o = (remain == '0);

      // R3
      wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         accept |=> !ready_o);

      // R3
      wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (remain == CW'(1)) |=> ready_o);

      // R2
      zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ready_o && !accept) |=> ready_o);
   end

endmodule

// File: rtl/ahbl_mem_store.sv
module ahbl_mem_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(DEPTH)-1:0]   wr_idx,
   input  logic [$clog2(DATA_W/8)-1:0] wr_lo,
   input  logic [2:0]                 wr_size,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx,
   output logic [DATA_W-1:0]          rd_data
);

   localparam int BYTES  = DATA_W / 8;
   localparam int LANE_W = $clog2(BYTES);

   if (DATA_W % 8 != 0 || (1 << LANE_W) != BYTES || BYTES < 2) begin : g_bad_width
      $error("store: DATA_W must be a power-of-two byte count of at least 16 bits");
   end
   if ((1 << $clog2(DEPTH)) != DEPTH || DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("store: DEPTH must be a power of two in 2..256");
   end

   // lanes touched by a transfer: aligned group of 2**size bytes holding wr_lo
   function automatic logic [BYTES-1:0] lane_sel(input logic [2:0] sz,
                                                 input logic [LANE_W-1:0] lo);
      int span_log;
      logic [BYTES-1:0] m;
      span_log = (int'(sz) > LANE_W) ? LANE_W : int'(sz);
      for (int b = 0; b < BYTES; b++) begin
         m[b] = ((b >> span_log) == (int'(lo) >> span_log));
      end
      return m;
   endfunction

   logic [DATA_W-1:0] words [DEPTH];
   logic [BYTES-1:0]  lane_en;

   assign lane_en = wr_en ? lane_sel(wr_size, wr_lo) : '0;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) words[w][8*b +: 8] <= '0;
         end else if (lane_en[b]) begin
            words[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
         end
      end
   end

   assign rd_data = words[rd_idx];

   // R6
   lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_size == 3'b000) |-> $onehot0(lane_en) && (lane_en != '0));

endmodule

// File: rtl/ahbl_mem_slave.sv
module ahbl_mem_slave
   import ahbl_mem_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 16,
   parameter int WAIT_STATES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_trans,
   input  logic              bus_write,
   input  logic [2:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ready,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready_out,
   output logic              bus_resp
);

   localparam int BYTES  = DATA_W / 8;
   localparam int LANE_W = $clog2(BYTES);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int KEEP_W = IDX_W + LANE_W;

   if (ADDR_W <= KEEP_W || ADDR_W > 64) begin : g_bad_addr
      $error("slave: ADDR_W must exceed the memory span bits and be at most 64");
   end

   logic              accept;
   logic              dp_active;
   logic              dp_write;
   logic [2:0]        dp_size;
   logic [KEEP_W-1:0] dp_addr;
   logic              own_ready;
   logic              commit_wr;
   logic [DATA_W-1:0] word_out;

   ahbl_mem_capture #(
      .ADDR_W (ADDR_W),
      .KEEP_W (KEEP_W)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (bus_sel),
      .kind      (bus_trans),
      .ready_in  (bus_ready),
      .write_in  (bus_write),
      .size_in   (bus_size),
      .addr_in   (bus_addr),
      .accept    (accept),
      .dp_active (dp_active),
      .dp_write  (dp_write),
      .dp_size   (dp_size),
      .dp_addr   (dp_addr)
   );

   ahbl_mem_waitgen #(
      .WAIT_STATES (WAIT_STATES)
   ) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .ready_o (own_ready)
   );

   // a write lands on the edge that ends its data phase
   assign commit_wr = dp_active && dp_write && own_ready;

   ahbl_mem_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit_wr),
      .wr_idx  (dp_addr[KEEP_W-1:LANE_W]),
      .wr_lo   (dp_addr[LANE_W-1:0]),
      .wr_size (dp_size),
      .wr_data (bus_wdata),
      .rd_idx  (dp_addr[KEEP_W-1:LANE_W]),
      .rd_data (word_out)
   );

   assign bus_rdata     = (dp_active && !dp_write) ? word_out : '0;
   assign bus_ready_out = own_ready;
   assign bus_resp      = RESP_OKAY;

   // R3
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ready_out) |-> dp_active);

   // R2
   no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && bus_ready) |=> !dp_active);

endmodule

// File: tb/tb_ahbl_mem_slave.sv
module tb_ahbl_mem_slave;

   localparam int DEPTH = 16;
   localparam int WAITS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [1:0]  bus_trans = 2'b00;
   logic        bus_write = 1'b0;
   logic [2:0]  bus_size = 3'b010;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready_out;
   logic        bus_resp;

   always #5 clk = ~clk;

   ahbl_mem_slave #(
      .ADDR_W (32), .DATA_W (32), .DEPTH (DEPTH), .WAIT_STATES (WAITS)
   ) dut (
      .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_addr (bus_addr),
      .bus_trans (bus_trans), .bus_write (bus_write), .bus_size (bus_size),
      .bus_wdata (bus_wdata), .bus_ready (bus_ready_out), .bus_rdata (bus_rdata),
      .bus_ready_out (bus_ready_out), .bus_resp (bus_resp)
   );

   int total = 0;
   int bad = 0;
   logic [31:0] model [DEPTH];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   bit          dp_valid = 0;
   bit          dp_read = 0;
   bit          mon_en = 0;
   bit          done = 0;
   int          low_cnt = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model_write(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
      int idx;
      int lo;
      idx = int'(a[5:2]);
      lo = int'(a[1:0]);
      for (int b = 0; b < 4; b++) begin
         bit hit;
         if (sz == 3'b000)      hit = (b == lo);
         else if (sz == 3'b001) hit = ((b >> 1) == (lo >> 1));
         else                   hit = 1;
         if (hit) model[idx][8*b +: 8] = d[8*b +: 8];
      end
   endfunction

   // driver: one address phase, then the matching write data in the data phase
   task automatic beat(input bit sel, input logic [1:0] tr, input bit wr, input logic [2:0] sz,
                       input logic [31:0] a, input logic [31:0] wd, input string tag);
      bit acc;
      bus_sel = sel; bus_trans = tr; bus_write = wr; bus_size = sz; bus_addr = a;
      acc = sel && tr[1];
      if (acc && !wr) begin
         exp_q.push_back(model[int'(a[5:2])]);
         tag_q.push_back(tag);
      end
      if (acc && wr) model_write(a, sz, wd);
      while (bus_ready_out !== 1'b1) @(negedge clk);
      @(negedge clk);
      dp_valid = acc;
      dp_read = acc && !wr;
      bus_wdata = wr ? wd : 32'h0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) beat(0, 2'b00, 0, 3'b010, 32'h0, 32'h0, "idle");
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_en) begin
         #2;
         // R9
         chk(bus_resp == 1'b0, "R9 resp", {31'b0, bus_resp}, 32'h0);
         if (dp_valid) begin
            if (!bus_ready_out) low_cnt++;
            else begin
               // R3
               chk(low_cnt == WAITS, "R3 wait count", low_cnt, WAITS);
               low_cnt = 0;
               if (dp_read) begin
                  if (exp_q.size() == 0) chk(0, "R5 unexpected read", bus_rdata, 32'h0);
                  else begin
                     logic [31:0] e;
                     string t;
                     e = exp_q.pop_front();
                     t = tag_q.pop_front();
                     chk(bus_rdata === e, t, bus_rdata, e);
                  end
               end else begin
                  // R5
                  chk(bus_rdata == 32'h0, "R5 rdata in write phase", bus_rdata, 32'h0);
               end
            end
         end else begin
            // R2
            chk(bus_ready_out == 1'b1, "R2 zero wait no-op", {31'b0, bus_ready_out}, 32'h1);
            // R5
            chk(bus_rdata == 32'h0, "R5 rdata idle", bus_rdata, 32'h0);
         end
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R1
      chk(bus_ready_out == 1'b1, "R1 ready in reset", {31'b0, bus_ready_out}, 32'h1);
      chk(bus_resp == 1'b0, "R1 resp in reset", {31'b0, bus_resp}, 32'h0);
      chk(bus_rdata == 32'h0, "R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_ready_out == 1'b1, "R1 ready after reset", {31'b0, bus_ready_out}, 32'h1);
      mon_en = 1;

      // R1 unwritten memory reads zero
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0038, 0, "R1 zero memory");
      // R4 word writes, pipelined burst (R8)
      beat(1, 2'b10, 1, 3'b010, 32'h0000_0000, 32'hA5A5_0001, "w");
      for (int i = 1; i < 8; i++)
         beat(1, 2'b11, 1, 3'b010, 32'(i*4), 32'hC0DE_0000 + 32'(i), "w");
      // R4 / R8 pipelined readback
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0000, 0, "R4 word readback");
      for (int i = 1; i < 8; i++)
         beat(1, 2'b11, 0, 3'b010, 32'(i*4), 0, "R4 word readback");
      idle(2);

      // R2 idle, busy, unselected requests carry writes that must not land
      beat(1, 2'b00, 1, 3'b010, 32'h0000_0000, 32'hDEAD_0000, "R2");
      beat(1, 2'b01, 1, 3'b010, 32'h0000_0000, 32'hDEAD_0001, "R2");
      beat(0, 2'b10, 1, 3'b010, 32'h0000_0000, 32'hDEAD_0002, "R2");
      beat(0, 2'b11, 1, 3'b010, 32'h0000_0004, 32'hDEAD_0003, "R2");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0000, 0, "R2 ignored write word0");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0004, 0, "R2 ignored write word1");

      // R6 byte writes, each lane into a word holding a known pattern
      beat(1, 2'b10, 1, 3'b010, 32'h0000_0010, 32'h1122_3344, "w");
      beat(1, 2'b10, 1, 3'b000, 32'h0000_0011, 32'hFFFF_AAFF, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0010, 0, "R6 byte lane1");
      beat(1, 2'b10, 1, 3'b000, 32'h0000_0013, 32'hBB00_0000, "w");
      beat(1, 2'b10, 1, 3'b000, 32'h0000_0010, 32'h0000_00CC, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0010, 0, "R6 byte lanes 0 and 3");
      beat(1, 2'b10, 1, 3'b000, 32'h0000_0016, 32'h00EE_0000, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0014, 0, "R6 byte lane2");

      // R7 halfword writes
      beat(1, 2'b10, 1, 3'b010, 32'h0000_0020, 32'h5555_6666, "w");
      beat(1, 2'b10, 1, 3'b001, 32'h0000_0022, 32'h9876_FFFF, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0020, 0, "R7 upper half");
      beat(1, 2'b10, 1, 3'b001, 32'h0000_0020, 32'hFFFF_1234, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0020, 0, "R7 lower half");

      // R10 aliasing through high address bits
      beat(1, 2'b10, 1, 3'b010, 32'h8000_0044, 32'h0A11_A5ED, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0004, 0, "R10 alias word1");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_0104, 0, "R10 alias high read");

      // R8 write immediately followed by read of the same word
      beat(1, 2'b10, 1, 3'b010, 32'h0000_003C, 32'hFEED_BEEF, "w");
      beat(1, 2'b10, 0, 3'b010, 32'h0000_003C, 0, "R8 write then read");
      beat(1, 2'b01, 0, 3'b010, 32'h0000_0000, 0, "busy");
      beat(1, 2'b11, 0, 3'b010, 32'h0000_0008, 0, "R8 read after busy");
      idle(3);

      chk(exp_q.size() == 0, "R5 all reads seen", exp_q.size(), 0);
      mon_en = 0;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule